// File: doc/BRIEF.md
# Pin function crossbar

This block is a register-programmed switch matrix between on-chip peripheral signals and the physical pins of a device. Each movable peripheral function owns one byte-wide selector that names the pin it uses. Selectors are packed four to a 32-bit pin-assign register. A function's identifier encodes its location: the register index in the upper nibble and the byte slot in the lower nibble. Its flat function number is therefore `4*register + slot`. For each pin, the crossbar forwards the output value and output enable of the function routed to it. Each movable input function is fed from the pin its selector names.

A separate pin-enable register is active low. It lets a fixed function claim its dedicated pin: fixed function k owns pin k. When the fixed function is enabled it overrides any movable output routed to that pin.

Software configures the block through a simple synchronous register port. Every routed output and the read data are registered, so each is one clock behind its cause. The number of pin-assign registers, pins and fixed functions are build parameters. The defaults give nine assign registers, 29 pins and nine fixed functions. In the default fixed list, bits 2, 3 and 6 are the debug clock, the debug data and the reset pin.

Top module: `pinx_crossbar`

## Requirements
- R1: A synchronous reset sets every selector to 0xFF. It loads the pin-enable register with all implemented bits at 1, except bits 2, 3 and 6, which are 0 (the default reset value is 0x1B3). It clears `cfg_rdata`, `pin_out`, `pin_oe`, `mov_in` and `fix_in`.
- R2: A write with `cfg_addr` below NUM_REGS stores `cfg_wdata` in pin-assign register `cfg_addr`. Byte slot s, at bits 8s+7:8s, is the selector of function 4*`cfg_addr`+s. `cfg_rdata` returns the register addressed one cycle earlier.
- R3: The pin-enable register sits at address NUM_REGS. Write bits at position NUM_FIXED and above are dropped and read back as 0. Addresses above NUM_REGS read 0, and writes to them change nothing.
- R4: One cycle after the configuration is in place, `pin_out[p]`/`pin_oe[p]` equal `mov_out[f]`/`mov_oe[f]` of a function f whose selector equals p.
- R5: When several movable functions select the same pin, the function with the lowest number drives it.
- R6: A selector of 0xFF, or any value of NUM_PINS or more, leaves its function unassigned. It drives no pin, and its `mov_in` reads 0.
- R7: `mov_in[f]` equals `pin_in` at the pin named by the selector of function f, one cycle later.
- R8: When pin-enable bit k is 0, pin k takes `fix_out[k]`/`fix_oe[k]`, overriding any movable function, and `fix_in[k]` follows `pin_in[k]`. When bit k is 1, `fix_in[k]` is 0.
- R9: A pin that no enabled fixed function and no movable function claims has `pin_out` and `pin_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (assign registers, then the pin-enable register) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's address |
| mov_out | input | NUM_REGS*4 | Output value of each movable function |
| mov_oe | input | NUM_REGS*4 | Output enable of each movable function |
| mov_in | output | NUM_REGS*4 | Input value delivered to each movable function |
| fix_out | input | NUM_FIXED | Output value of each fixed function |
| fix_oe | input | NUM_FIXED | Output enable of each fixed function |
| fix_in | output | NUM_FIXED | Input value delivered to each fixed function |
| pin_in | input | NUM_PINS | Value sensed at each pin |
| pin_out | output | NUM_PINS | Value driven toward each pin |
| pin_oe | output | NUM_PINS | Output enable toward each pin |

## Verification
The assertions assume `rst` is held for at least one edge before the first check matters. They also assume `cfg_addr` and `cfg_wdata` are stable across the edge at which `cfg_we` is sampled. The stimulus meets both conditions by changing every input only on the falling clock edge, and by starting with several cycles of reset. The assertions further assume NUM_PINS stays below 255, so that 0xFF can never name a real pin. Every bench configuration keeps to that limit. Some selectors point past the last pin; the bench uses these to exercise the out-of-range rule, never to rely on it.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
  localparam int SLOTS   = 4;
  localparam int SEL_W   = 8;
  localparam int WORD_W  = SLOTS * SEL_W;
  localparam logic [SEL_W-1:0] SEL_NONE = 8'hFF;
endpackage

// File: rtl/pinx_regs.sv
module pinx_regs
  import pinx_pkg::*;
#(
  parameter int NUM_REGS  = 9,
  parameter int NUM_FIXED = 9,
  parameter logic [31:0] EN_RESET = 32'h0000_01B3,
  localparam int AW = $clog2(NUM_REGS + 1),
  localparam int NUM_FUNCS = NUM_REGS * SLOTS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata,
  output logic [NUM_FUNCS*SEL_W-1:0] sel_o,
  output logic [NUM_FIXED-1:0]       en_n_o
);
  localparam logic [AW-1:0] EN_ADDR = AW'(NUM_REGS);

  logic [WORD_W-1:0]    asg_q [NUM_REGS];
  logic [NUM_FIXED-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) asg_q[i] <= {SLOTS{SEL_NONE}};
      en_q <= EN_RESET[NUM_FIXED-1:0];
    end else if (wr_en) begin
      if (addr < EN_ADDR) asg_q[addr] <= wdata;
      else if (addr == EN_ADDR) en_q <= wdata[NUM_FIXED-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (addr < EN_ADDR) rdata <= asg_q[addr];
    else if (addr == EN_ADDR) rdata <= WORD_W'(en_q);
    else rdata <= '0;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
    assign sel_o[i*WORD_W +: WORD_W] = asg_q[i];
  end
  assign en_n_o = en_q;

  // R2: a write to an assign register is visible in the bank on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr < EN_ADDR) |=> (asg_q[$past(addr)] == $past(wdata)));

  // R3: reserved enable bits never read back as 1
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == EN_ADDR) |=> ((rdata >> NUM_FIXED) == '0));

  // R3: addresses past the enable register read as zero
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (addr > EN_ADDR) |=> (rdata == '0));
endmodule

// File: rtl/pinx_out_route.sv
module pinx_out_route
  import pinx_pkg::*;
#(
  parameter int NUM_PINS  = 29,
  parameter int NUM_FUNCS = 36,
  parameter int NUM_FIXED = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FUNCS*SEL_W-1:0] sel,
  input  logic [NUM_FIXED-1:0]       en_n,
  input  logic [NUM_FUNCS-1:0]       mov_out,
  input  logic [NUM_FUNCS-1:0]       mov_oe,
  input  logic [NUM_FIXED-1:0]       fix_out,
  input  logic [NUM_FIXED-1:0]       fix_oe,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe
);
  logic [NUM_PINS-1:0] mv_out, mv_oe, nx_out, nx_oe;

  // scan from the highest function down so the lowest number is applied last
  always_comb begin
    mv_out = '0;
    mv_oe  = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int f = NUM_FUNCS - 1; f >= 0; f--) begin
        if (sel[f*SEL_W +: SEL_W] == p[SEL_W-1:0]) begin
          mv_out[p] = mov_out[f];
          mv_oe[p]  = mov_oe[f];
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p < NUM_FIXED) begin : g_fixed
      assign nx_out[p] = en_n[p] ? mv_out[p] : fix_out[p];
      assign nx_oe[p]  = en_n[p] ? mv_oe[p]  : fix_oe[p];
    end else begin : g_plain
      assign nx_out[p] = mv_out[p];
      assign nx_oe[p]  = mv_oe[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nx_out;
      pin_oe  <= nx_oe;
    end
  end

  // R1: the edge after reset leaves every pin undriven
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0));

  for (genvar k = 0; k < NUM_FIXED; k++) begin : g_chk
    // R8: an enabled fixed function owns its pin
    a_r8_fixed_wins: assert property (@(posedge clk) disable iff (rst)
      !en_n[k] |=> (pin_out[k] == $past(fix_out[k]) && pin_oe[k] == $past(fix_oe[k])));
  end
endmodule

// File: rtl/pinx_in_route.sv
module pinx_in_route
  import pinx_pkg::*;
#(
  parameter int NUM_PINS  = 29,
  parameter int NUM_FUNCS = 36,
  parameter int NUM_FIXED = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FUNCS*SEL_W-1:0] sel,
  input  logic [NUM_FIXED-1:0]       en_n,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_FUNCS-1:0]       mov_in,
  output logic [NUM_FIXED-1:0]       fix_in
);
  localparam int PAD_W = 1 << SEL_W;

  // pins padded with zeros so any out-of-range selector picks a 0
  logic [PAD_W-1:0]     pin_pad;
  logic [NUM_FUNCS-1:0] mv_d;
  logic [NUM_FIXED-1:0] fx_d;

  assign pin_pad = PAD_W'(pin_in);

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
    assign mv_d[f] = pin_pad[sel[f*SEL_W +: SEL_W]];
  end
  for (genvar k = 0; k < NUM_FIXED; k++) begin : g_fix
    assign fx_d[k] = ~en_n[k] & pin_in[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mov_in <= '0;
      fix_in <= '0;
    end else begin
      mov_in <= mv_d;
      fix_in <= fx_d;
    end
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_chk
    // R6: an unassigned movable input reads zero
    a_r6_unassigned_low: assert property (@(posedge clk) disable iff (rst)
      (sel[f*SEL_W +: SEL_W] >= SEL_W'(NUM_PINS)) |=> (mov_in[f] == 1'b0));
  end
  for (genvar k = 0; k < NUM_FIXED; k++) begin : g_fchk
    // R8: a disabled fixed function sees no pin activity
    a_r8_fixed_off_low: assert property (@(posedge clk) disable iff (rst)
      en_n[k] |=> (fix_in[k] == 1'b0));
  end
endmodule

// File: rtl/pinx_crossbar.sv
module pinx_crossbar
  import pinx_pkg::*;
#(
  parameter int NUM_REGS  = 9,
  parameter int NUM_PINS  = 29,
  parameter int NUM_FIXED = 9,
  parameter logic [31:0] EN_RESET = 32'h0000_01B3,
  localparam int NUM_FUNCS = NUM_REGS * SLOTS,
  localparam int AW = $clog2(NUM_REGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  input  logic [NUM_FUNCS-1:0] mov_out,
  input  logic [NUM_FUNCS-1:0] mov_oe,
  output logic [NUM_FUNCS-1:0] mov_in,
  input  logic [NUM_FIXED-1:0] fix_out,
  input  logic [NUM_FIXED-1:0] fix_oe,
  output logic [NUM_FIXED-1:0] fix_in,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe
);
  logic [NUM_FUNCS*SEL_W-1:0] sel;
  logic [NUM_FIXED-1:0]       en_n;

  pinx_regs #(
    .NUM_REGS(NUM_REGS), .NUM_FIXED(NUM_FIXED), .EN_RESET(EN_RESET)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .sel_o(sel), .en_n_o(en_n)
  );

  pinx_out_route #(
    .NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .NUM_FIXED(NUM_FIXED)
  ) out_i (
    .clk(clk), .rst(rst), .sel(sel), .en_n(en_n),
    .mov_out(mov_out), .mov_oe(mov_oe), .fix_out(fix_out), .fix_oe(fix_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  pinx_in_route #(
    .NUM_PINS(NUM_PINS), .NUM_FUNCS(NUM_FUNCS), .NUM_FIXED(NUM_FIXED)
  ) in_i (
    .clk(clk), .rst(rst), .sel(sel), .en_n(en_n), .pin_in(pin_in),
    .mov_in(mov_in), .fix_in(fix_in)
  );
endmodule

// File: tb/pinx_crossbar_tb_top.sv
`timescale 1ns/1ps
module pinx_crossbar_tb_top;
  localparam int NR = 9;
  localparam int NP = 29;
  localparam int NX = 9;
  localparam int NF = NR * 4;
  localparam int AW = 4;
  localparam int NV = 9;

  localparam logic [AW-1:0] V_ADDR [NV] = '{4'd0, 4'd1, 4'd2, 4'd9, 4'd9, 4'd9, 4'd12, 4'd8, 4'd0};
  localparam logic [31:0] V_DATA [NV] = '{32'h03020100, 32'hFF1C0504, 32'h051D0007,
    32'hFFFFFFFF, 32'hFFFFFE00, 32'h000001FA, 32'h12345678, 32'h1B1A1918, 32'hFFFFFFFF};
  localparam logic [31:0] V_RB [NV] = '{32'h03020100, 32'hFF1C0504, 32'h051D0007,
    32'h000001FF, 32'h00000000, 32'h000001FA, 32'h00000000, 32'h1B1A1918, 32'hFFFFFFFF};
  localparam logic [NP-1:0] V_PIN [NV] = '{29'h1FFFFFFF, 29'h0AAAAAAA, 29'h15555555,
    29'h1FFFFFFF, 29'h00F0F0F0, 29'h01234567, 29'h00000000, 29'h1F000000, 29'h0FFFFFFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NF-1:0] mov_out = 36'h5_3C96_A5E1;
  logic [NF-1:0] mov_oe  = 36'hC_F0F5_5A3F;
  logic [NF-1:0] mov_in;
  logic [NX-1:0] fix_out = 9'h155;
  logic [NX-1:0] fix_oe  = 9'h0F3;
  logic [NX-1:0] fix_in;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_asg [NR];
  logic [NX-1:0] m_en;

  always #4 clk = ~clk;

  pinx_crossbar dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mov_out(mov_out), .mov_oe(mov_oe), .mov_in(mov_in),
    .fix_out(fix_out), .fix_oe(fix_oe), .fix_in(fix_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NR; i++) m_asg[i] = 32'hFFFFFFFF;
    m_en = 9'h1B3;
  endtask

  function automatic logic [7:0] m_sel(input int f);
    return m_asg[f / 4][(f % 4) * 8 +: 8];
  endfunction

  task automatic cfg_write(input logic [AW-1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'(NR)) m_asg[a] = d;
    else if (a == 4'(NR)) m_en = d[NX-1:0];
  endtask

  task automatic cfg_read(input logic [AW-1:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // expected routing from the requirements, compared after the outputs have settled
  task automatic model_check(input string where);
    logic [NP-1:0] eo, eoe;
    logic [NF-1:0] emi;
    logic [NX-1:0] efi;
    for (int p = 0; p < NP; p++) begin
      eo[p] = 1'b0; eoe[p] = 1'b0;
      for (int f = NF - 1; f >= 0; f--)
        if (int'(m_sel(f)) == p) begin eo[p] = mov_out[f]; eoe[p] = mov_oe[f]; end
      if (p < NX && !m_en[p]) begin eo[p] = fix_out[p]; eoe[p] = fix_oe[p]; end
    end
    for (int f = 0; f < NF; f++)
      emi[f] = (int'(m_sel(f)) < NP) ? pin_in[m_sel(f)] : 1'b0;
    for (int k = 0; k < NX; k++) efi[k] = !m_en[k] & pin_in[k];
    chk({"R4 R5 R8 R9 pin_out ", where}, 64'(pin_out), 64'(eo));
    chk({"R4 R5 R8 R9 pin_oe ", where}, 64'(pin_oe), 64'(eoe));
    chk({"R6 R7 mov_in ", where}, 64'(mov_in), 64'(emi));
    chk({"R8 fix_in ", where}, 64'(fix_in), 64'(efi));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pin_oe in reset", 64'(pin_oe), 64'h0);
    chk("R1 rdata in reset", 64'(cfg_rdata), 64'h0);
    rst = 1'b0;
    cfg_read(4'd0, rb);
    chk("R1 assign reset value", 64'(rb), 64'hFFFFFFFF);
    cfg_read(4'd9, rb);
    chk("R1 enable reset value", 64'(rb), 64'h1B3);
    model_check("after reset");

    for (int v = 0; v < NV; v++) begin
      pin_in = V_PIN[v];
      cfg_write(V_ADDR[v], V_DATA[v]);
      cfg_read(V_ADDR[v], rb);
      chk($sformatf("R2 R3 readback vec %0d", v), 64'(rb), 64'(V_RB[v]));
      model_check($sformatf("vec %0d", v));
    end

    // R5: functions 0 and 9 both on pin 0, fixed functions released
    cfg_write(4'd9, 32'h1FF);
    cfg_write(4'd0, 32'hFFFFFF00);
    cfg_read(4'd0, rb);
    chk("R5 lowest function drives pin0", 64'({pin_oe[0], pin_out[0]}), 64'({mov_oe[0], mov_out[0]}));
    model_check("R5 conflict");

    // R8: fixed function 0 claims pin 0 over both movable functions
    pin_in = 29'h00000001;
    cfg_write(4'd9, 32'h1FE);
    cfg_read(4'd9, rb);
    chk("R8 fixed drives pin0", 64'({pin_oe[0], pin_out[0]}), 64'({fix_oe[0], fix_out[0]}));
    chk("R8 fix_in follows pin", 64'(fix_in[0]), 64'h1);
    model_check("R8 override");

    // R3: write past the enable register changes nothing observable
    cfg_write(4'd15, 32'h00000000);
    cfg_read(4'd9, rb);
    chk("R3 unmapped write ignored", 64'(rb), 64'h1FE);
    model_check("R3 unmapped");

    // R1: reset in mid-run restores defaults
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    cfg_read(4'd2, rb);
    chk("R1 mid-run reset assign", 64'(rb), 64'hFFFFFFFF);
    model_check("R1 mid-run reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule